// File: doc/BRIEF.md
# Serial Wiper Register Interface with Chain Pass-Through

This block is a mode-0 serial peripheral slave that owns a tiny volatile register file: two wiper position registers and one control register. A host selects the block with an active-low select, clocks 16-bit words made of a 3-bit opcode, a 5-bit register address and an 8-bit data byte, and releases select to commit the last word. Register contents are presented in parallel to the analog wiper logic. The control register also drives an active-low shutdown line and chooses whether the serial output drives both levels or only pulls low.

All serial inputs are sampled with the block's own fast clock, and the block detects edges on them. Between commits the block is a 16-bit shift stage, so several blocks wired output-to-input can be loaded by one long frame and all commit on the same select release. A read command is answered by a 16-bit response word: the tag 111, then the 5-bit register address, then the register value. A four-byte frame therefore reads one register, and a read left as the last word of a frame is answered at the start of the next frame.

Top module: `spi_dcp_regif`

## Requirements
- R1: After reset both wiper outputs are 40h, the control output is 40h, shutdownN is 1, sdoOpenDrain is 0 and sdoOe is 0.
- R2: Opcode 110 with address 00000 or 00001 loads data bits 6:0 into wiper 0 or wiper 1, and only after select rises; data bit 7 is dropped.
- R3: Opcode 011 with any address, or opcode 110 with address 10000, loads the control register with only bits 6 and 1 kept and all others 0; shutdownN follows bit 6 and sdoOpenDrain follows bit 1.
- R4: No register changes for the opcodes 000, 001, 010, 100, 101 and 111, nor for opcode 110 with any address other than 00000, 00001 and 10000.
- R5: In a 32-bit frame whose first word is a read (opcode 100 with an address, or opcode 001 which means address 10000), bits 17 to 32 on sdo are 111, the address, and the register value (wiper values zero-extended, 00h for unmapped addresses).
- R6: Words that are not reads leave sdo as the sdi stream delayed by 16 SCK cycles, and the last word of a frame is shifted out first in the next frame.
- R7: A frame longer than 16 bits commits only its last 16 bits; a frame shorter than 16 bits commits nothing.
- R8: Until select has fallen once after reset, SCK activity and select release have no effect and sdoOe stays 0.
- R9: sdoOe is 0 while select is high; in push-pull mode it is 1 during a frame; in open-drain mode it is 1 only while sdo is 0.
- R10: A read word that ends a frame makes the first 16 bits of the next frame the response word of R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock used to sample the serial lines |
| rstN | input | 1 | Active-low asynchronous-style reset, applied synchronously |
| csN | input | 1 | Active-low select; its release commits the last word |
| sck | input | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial data in, sampled on SCK rise |
| sdo | output | 1 | Serial data out, changed on SCK fall |
| sdoOe | output | 1 | Output enable for sdo |
| sdoOpenDrain | output | 1 | High when the output is in pull-low-only mode |
| shutdownN | output | 1 | Active-low shutdown request to the wipers |
| wiper0 | output | 7 | Position of wiper 0 |
| wiper1 | output | 7 | Position of wiper 1 |
| ctrlOut | output | 8 | Control register contents |

## Verification
Each serial line passes two sampling flops and an edge flop, so an SCK fall reaches sdo about four clocks later, and a select release reaches the registers about four clocks later. The bench holds every SCK phase for eight clocks and samples sdo just before the next rise, then reads the register outputs sixteen clocks after select has risen, well past the due cycle. Register outputs are also read just before select rises, to show that nothing moves before the commit.

// File: rtl/spi_dcp_pkg.sv
package spi_dcp_pkg;
  localparam int OP_W      = 3;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 8;
  localparam int WORD_W    = OP_W + ADDR_W + DATA_W;
  localparam int NUM_WIPERS = 2;

  localparam logic [OP_W-1:0] OP_NOP     = 3'b000;
  localparam logic [OP_W-1:0] OP_RD_CTRL = 3'b001;
  localparam logic [OP_W-1:0] OP_WR_CTRL = 3'b011;
  localparam logic [OP_W-1:0] OP_RD_ADDR = 3'b100;
  localparam logic [OP_W-1:0] OP_WR_ADDR = 3'b110;
  localparam logic [OP_W-1:0] RESP_TAG   = 3'b111;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 5'h10;

  localparam int SHDN_BIT = 6;
  localparam int OD_BIT   = 1;
  localparam logic [DATA_W-1:0] CTRL_MASK  = 8'h42;
  localparam logic [DATA_W-1:0] CTRL_RESET = 8'h40;

  typedef struct packed {
    logic shiftEn;    // SCK rise inside a selected frame
    logic fallEn;     // SCK fall inside a selected frame
    logic startEn;    // select fell
    logic wordDone;   // this rise completes a 16-bit word
    logic execEn;     // select rose after at least one full word
    logic respAtEnd;  // commit happens off a word boundary
  } strobes_t;
endpackage

// File: rtl/spi_dcp_ctrl.sv
module spi_dcp_ctrl
  import spi_dcp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     csN,
  input  logic     sck,
  input  logic     sdi,
  output strobes_t stb,
  output logic     sdiS,
  output logic     active
);
  localparam int CNT_W = $clog2(WORD_W);

  logic [SYNC_STAGES-1:0] csSync, sckSync, sdiSync;
  logic csPrev, sckPrev;
  logic armed, frameLong;
  logic [CNT_W-1:0] bitCnt;

  logic csLvl, sckLvl, csFall, csRise, sckRise, sckFall, lastBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csSync  <= '0;
      sckSync <= '0;
      sdiSync <= '0;
      csPrev  <= 1'b0;
      sckPrev <= 1'b0;
    end else begin
      csSync  <= {csSync[SYNC_STAGES-2:0], csN};
      sckSync <= {sckSync[SYNC_STAGES-2:0], sck};
      sdiSync <= {sdiSync[SYNC_STAGES-2:0], sdi};
      csPrev  <= csLvl;
      sckPrev <= sckLvl;
    end
  end

  assign csLvl   = csSync[SYNC_STAGES-1];
  assign sckLvl  = sckSync[SYNC_STAGES-1];
  assign sdiS    = sdiSync[SYNC_STAGES-1];
  assign csFall  = csPrev & ~csLvl;
  assign csRise  = ~csPrev & csLvl;
  assign active  = armed & ~csLvl;
  assign sckRise = active & sckLvl & ~sckPrev;
  assign sckFall = active & ~sckLvl & sckPrev;
  assign lastBit = (bitCnt == CNT_W'(WORD_W - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed     <= 1'b0;
      frameLong <= 1'b0;
      bitCnt    <= '0;
    end else begin
      if (csFall) begin
        armed     <= 1'b1;
        frameLong <= 1'b0;
        bitCnt    <= '0;
      end else if (sckRise) begin
        bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
        if (lastBit) frameLong <= 1'b1;
      end
    end
  end

  always_comb begin
    stb.shiftEn   = sckRise;
    stb.fallEn    = sckFall;
    stb.startEn   = csFall;
    stb.wordDone  = sckRise & lastBit;
    stb.execEn    = csRise & armed & frameLong;
    stb.respAtEnd = csRise & armed & frameLong & (bitCnt != '0);
  end
endmodule

// File: rtl/spi_dcp_datapath.sv
module spi_dcp_datapath
  import spi_dcp_pkg::*;
#(
  parameter int WIPER_W = 7
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  strobes_t                            stb,
  input  logic                                sdiS,
  output logic                                sdoBit,
  output logic [NUM_WIPERS-1:0][WIPER_W-1:0]  wiperQ,
  output logic [DATA_W-1:0]                   ctrlReg
);
  localparam logic [WIPER_W-1:0] MID = WIPER_W'(1) << (WIPER_W - 1);

  logic [WORD_W-1:0] rawWord, shiftReg, nextRaw, word, resp;
  logic [OP_W-1:0]   op;
  logic [ADDR_W-1:0] addr, effAddr;
  logic [DATA_W-1:0] data, readData;
  logic              readHit, writeHit, ctrlOp;

  assign nextRaw = {rawWord[WORD_W-2:0], sdiS};
  assign word    = stb.wordDone ? nextRaw : rawWord;
  assign op      = word[WORD_W-1 -: OP_W];
  assign addr    = word[DATA_W +: ADDR_W];
  assign data    = word[DATA_W-1:0];

  assign ctrlOp   = (op == OP_RD_CTRL) || (op == OP_WR_CTRL);
  assign effAddr  = ctrlOp ? ADDR_CTRL : addr;
  assign readHit  = (op == OP_RD_CTRL) || (op == OP_RD_ADDR);
  assign writeHit = (op == OP_WR_CTRL) || (op == OP_WR_ADDR);

  always_comb begin
    readData = '0;
    if (effAddr == ADDR_CTRL) readData = ctrlReg;
    for (int i = 0; i < NUM_WIPERS; i++)
      if (effAddr == ADDR_W'(i)) readData = DATA_W'(wiperQ[i]);
  end

  assign resp = {RESP_TAG, effAddr, readData};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawWord  <= '0;
      shiftReg <= '0;
      sdoBit   <= 1'b0;
    end else begin
      if (stb.shiftEn) begin
        rawWord <= nextRaw;
        if (stb.wordDone && readHit) shiftReg <= resp;
        else                         shiftReg <= {shiftReg[WORD_W-2:0], sdiS};
      end else if (stb.respAtEnd && readHit) begin
        shiftReg <= resp;
      end
      if (stb.startEn || stb.fallEn) sdoBit <= shiftReg[WORD_W-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= CTRL_RESET;
      for (int i = 0; i < NUM_WIPERS; i++) wiperQ[i] <= MID;
    end else if (stb.execEn && writeHit) begin
      if (effAddr == ADDR_CTRL) ctrlReg <= data & CTRL_MASK;
      for (int i = 0; i < NUM_WIPERS; i++)
        if (effAddr == ADDR_W'(i)) wiperQ[i] <= data[WIPER_W-1:0];
    end
  end
endmodule

// File: rtl/spi_dcp_regif.sv
module spi_dcp_regif
  import spi_dcp_pkg::*;
#(
  parameter int WIPER_W     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               csN,
  input  logic               sck,
  input  logic               sdi,
  output logic               sdo,
  output logic               sdoOe,
  output logic               sdoOpenDrain,
  output logic               shutdownN,
  output logic [WIPER_W-1:0] wiper0,
  output logic [WIPER_W-1:0] wiper1,
  output logic [DATA_W-1:0]  ctrlOut
);
  strobes_t stb;
  logic sdiS, active, sdoBit;
  logic [NUM_WIPERS-1:0][WIPER_W-1:0] wiperQ;
  logic [DATA_W-1:0] ctrlReg;

  spi_dcp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .sdi(sdi),
    .stb(stb), .sdiS(sdiS), .active(active)
  );

  spi_dcp_datapath #(.WIPER_W(WIPER_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdiS(sdiS),
    .sdoBit(sdoBit), .wiperQ(wiperQ), .ctrlReg(ctrlReg)
  );

  assign sdo          = sdoBit;
  assign sdoOpenDrain = ctrlReg[OD_BIT];
  assign sdoOe        = active & (~ctrlReg[OD_BIT] | ~sdoBit);
  assign shutdownN    = ctrlReg[SHDN_BIT];
  assign wiper0       = wiperQ[0];
  assign wiper1       = wiperQ[1];
  assign ctrlOut      = ctrlReg;
endmodule

// File: rtl/spi_dcp_regif_chk.sv
module spi_dcp_regif_chk #(
  parameter int WIPER_W = 7
) (
  input logic               clk,
  input logic               rstN,
  input logic               csN,
  input logic               sdoOe,
  input logic               shutdownN,
  input logic [WIPER_W-1:0] wiper0,
  input logic [WIPER_W-1:0] wiper1,
  input logic [7:0]         ctrlOut
);
  localparam logic [WIPER_W-1:0] MID = WIPER_W'(1) << (WIPER_W - 1);

  assert_reset_values_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (wiper0 == MID && wiper1 == MID && ctrlOut == 8'h40 && shutdownN));

  // R2: a wiper moves only once select has been high for the commit path
  assert_wiper0_commit_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wiper0) |-> $past(csN, 3));

  assert_wiper1_commit_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wiper1) |-> $past(csN, 3));

  assert_ctrl_commit_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctrlOut) |-> ($past(csN, 3) && ((ctrlOut & 8'hBD) == 8'h00)));

  assert_released_when_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(csN, 2) |-> !sdoOe);
endmodule

bind spi_dcp_regif spi_dcp_regif_chk #(.WIPER_W(WIPER_W)) i_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .sdoOe(sdoOe), .shutdownN(shutdownN),
  .wiper0(wiper0), .wiper1(wiper1), .ctrlOut(ctrlOut)
);

// File: tb/test_spi_dcp_regif.sv
module test_spi_dcp_regif;
  logic clk = 1'b0;
  logic rstN, csN, sck, sdi;
  logic sdo, sdoOe, sdoOpenDrain, shutdownN;
  logic [6:0] wiper0, wiper1;
  logic [7:0] ctrlOut;

  int checks = 0;
  int fails  = 0;
  int oeLow, oeHigh1;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_dcp_regif i_spi_dcp_regif (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdoOe(sdoOe), .sdoOpenDrain(sdoOpenDrain), .shutdownN(shutdownN),
    .wiper0(wiper0), .wiper1(wiper1), .ctrlOut(ctrlOut)
  );

  // frame[37:22], wiper0[21:15], wiper1[14:8], ctrl[7:0]
  localparam logic [37:0] VECS [12] = '{
    {16'hC025, 7'h25, 7'h40, 8'h40},  // R2 wiper0
    {16'hC1FF, 7'h25, 7'h7F, 8'h40},  // R2 wiper1, bit 7 dropped
    {16'h6AFF, 7'h25, 7'h7F, 8'h42},  // R3 opcode 011, address ignored, mask
    {16'hD000, 7'h25, 7'h7F, 8'h00},  // R3 opcode 110 at 10000, shutdown
    {16'hC233, 7'h25, 7'h7F, 8'h00},  // R4 unmapped address
    {16'h8055, 7'h25, 7'h7F, 8'h00},  // R4 read opcode
    {16'hE011, 7'h25, 7'h7F, 8'h00},  // R4 opcode 111
    {16'h4011, 7'h25, 7'h7F, 8'h00},  // R4 opcode 010
    {16'h2F12, 7'h25, 7'h7F, 8'h00},  // R4 opcode 001
    {16'h1F77, 7'h25, 7'h7F, 8'h00},  // R4 opcode 000
    {16'hD0C0, 7'h25, 7'h7F, 8'h40},  // R3 restore
    {16'hC080, 7'h00, 7'h7F, 8'h40}   // R2 bit 7 dropped
  };

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [63:0] bits, input int n, input bit sel,
                      output logic [63:0] got);
    got = '0; oeLow = 0; oeHigh1 = 0;
    if (sel) begin csN = 1'b0; idle(8); end
    for (int i = 0; i < n; i++) begin
      sdi = bits[n-1-i];
      idle(8);
      got[n-1-i] = sdoOe ? sdo : 1'b1;
      if (!sdoOe) oeLow++;
      else if (sdo) oeHigh1++;
      sck = 1'b1;
      idle(8);
      sck = 1'b0;
    end
    idle(8);
    if (sel) begin csN = 1'b1; idle(16); end
  endtask

  function automatic logic [63:0] regs();
    return {41'd0, wiper0, wiper1, shutdownN, sdoOpenDrain, ctrlOut};
  endfunction

  function automatic logic [63:0] expRegs(input logic [6:0] w0, input logic [6:0] w1,
                                          input logic [7:0] c);
    return {41'd0, w0, w1, c[6], c[1], c};
  endfunction

  initial begin
    logic [63:0] got;
    rstN = 1'b0; csN = 1'b0; sck = 1'b0; sdi = 1'b0;
    idle(10);
    rstN = 1'b1;
    idle(4);
    check("R1 reset regs", regs(), expRegs(7'h40, 7'h40, 8'h40));
    check("R1 reset oe", {63'd0, sdoOe}, 64'd0);

    // R8: select never fell since reset
    xfer(64'hC011, 16, 1'b0, got);
    check("R8 oe held low", 64'(oeLow), 64'd16);
    csN = 1'b1; idle(16);
    check("R8 no commit", regs(), expRegs(7'h40, 7'h40, 8'h40));

    for (int i = 0; i < 12; i++) begin
      xfer(64'(VECS[i][37:22]), 16, 1'b1, got);
      check($sformatf("R2/R3/R4 vector %0d", i), regs(),
            expRegs(VECS[i][21:15], VECS[i][14:8], VECS[i][7:0]));
    end

    // R5: four-byte reads
    xfer({32'd0, 16'h8100, 16'h0000}, 32, 1'b1, got);
    check("R5 read wiper1", got[15:0], 64'hE17F);
    check("R9 push-pull oe", 64'(oeLow), 64'd0);
    xfer({32'd0, 16'h8300, 16'h0000}, 32, 1'b1, got);
    check("R5 read unmapped", got[15:0], 64'hE300);
    xfer({32'd0, 16'h2700, 16'h0000}, 32, 1'b1, got);
    check("R5 read ctrl via 001", got[15:0], 64'hF040);

    // R10: read left as last word
    xfer(64'hC05A, 16, 1'b1, got);
    xfer(64'h8000, 16, 1'b1, got);
    xfer(64'h0000, 16, 1'b1, got);
    check("R10 response next frame", got[15:0], 64'hE05A);

    // R6: shift-through
    xfer({32'd0, 16'h1234, 16'h0ABC}, 32, 1'b1, got);
    check("R6 delayed stream", got[15:0], 64'h1234);
    xfer(64'h0000, 16, 1'b1, got);
    check("R6 last word next frame", got[15:0], 64'h0ABC);
    check("R6 no commit", regs(), expRegs(7'h5A, 7'h7F, 8'h40));

    // R7: long and short frames, register read before commit
    csN = 1'b0; idle(8);
    check("R2 no change before commit", regs(), expRegs(7'h5A, 7'h7F, 8'h40));
    csN = 1'b1; idle(16);
    xfer({40'd0, 8'hFF, 16'hC013}, 24, 1'b1, got);
    check("R7 long frame last 16", regs(), expRegs(7'h13, 7'h7F, 8'h40));
    xfer(64'hC12, 12, 1'b1, got);
    check("R7 short frame ignored", regs(), expRegs(7'h13, 7'h7F, 8'h40));

    // R9: open-drain output
    xfer(64'h6002, 16, 1'b1, got);
    check("R3 ctrl open-drain", regs(), expRegs(7'h13, 7'h7F, 8'h02));
    xfer({32'd0, 16'h8100, 16'h0000}, 32, 1'b1, got);
    check("R9 open-drain read data", got[15:0], 64'hE17F);
    check("R9 never drives high", 64'(oeHigh1), 64'd0);
    check("R9 releases on ones", 64'(oeLow > 0), 64'd1);
    check("R9 idle oe", {63'd0, sdoOe}, 64'd0);
    xfer(64'h6040, 16, 1'b1, got);
    check("R3 ctrl restore", regs(), expRegs(7'h13, 7'h7F, 8'h40));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule